// File: doc/BRIEF.md
# Stream-to-Memory Transfer Engine

This block copies a run of 32-bit words from one of several device-side valid/ready streams into memory, one word per write request, with no processor help per word. Software programs a physical start address and a word count, and then writes a command word. The command word enables the transfer, enables the interrupt, and selects the source stream. The engine then presents each word from the selected stream as a memory write. The words go to consecutive word addresses. When the count is used up, the engine reports completion.

A memory error response stops the run early and sets an error flag. Completion and error both raise a level interrupt when the interrupt is enabled. The interrupt stays up until software clears the status bit that caused it. The address is taken as physical, and the engine does no translation.

Top module: `dma_wr_engine`

## Requirements
- R1: Register port (write strobe, 4-bit byte offset, 32-bit write data, combinational read data). Offset 0x0 is the start address, 0x4 the word count and 0x8 the command. In the command word, bit0 is the transfer enable, bit1 the interrupt enable and bit2 the source select. Offset 0xC is status: bit0 busy, bit1 done, bit2 error. The first three registers read back what was written. After reset every register and status bit reads 0 and irq is low.
- R2: Writing the command word with bit0 = 1 while idle, with a nonzero count, sets busy. The first memory write then goes to the programmed start address.
- R3: A write is accepted in a cycle with mem_req and mem_gnt high and mem_err low. It carries the selected stream's current word on mem_wdata, and that word is consumed in the same cycle. The next request goes to the address plus 4. While the stream has no valid word, no request is made.
- R4: After exactly count accepted writes, busy clears and done sets, and no further request is made.
- R5: A start with a count of 0 sets done on the next cycle and makes no memory request.
- R6: The source select picks stream 0 or stream 1. The ready of the unselected stream stays low.
- R7: mem_err high with a granted request ends the transfer. busy clears, error sets and done stays clear. The errored word is not counted as written.
- R8: irq is high exactly when (done or error) is set and the interrupt enable is set. Writing 1 to status bit1 or bit2 clears done or error, and writing 0 to them leaves them unchanged.
- R9: While busy, writes to the start address, count and command registers are ignored.
- R10: A command write with bit0 = 0 starts nothing and makes no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| dev_valid | input | 2 | Per-stream word valid |
| dev_data | input | 64 | Per-stream word, stream n in bits [32n+31:32n] |
| dev_ready | output | 2 | Per-stream word consumed |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_err | input | 1 | Error response for the granted request |
| irq | output | 1 | Completion or error interrupt |

## Verification
The assertions check on every cycle that requests only appear while busy and that the address steps by 4 after each accepted non-final write. They also check that at most one stream is ready, that the final write or an error ends the run with the matching flag, that a zero-count start completes without a request, that address and count stay frozen during a run, and that the interrupt only drops after a register write. Only the bench scenarios can show the transferred data and its order per stream, the exact number of writes, the readback values, the effect of the interrupt enable, and the result of a run stalled by both the stream and the memory grant.

// File: rtl/dmaeng_pkg.sv
package dmaeng_pkg;
  localparam logic [3:0] OFS_BASE   = 4'h0;
  localparam logic [3:0] OFS_COUNT  = 4'h4;
  localparam logic [3:0] OFS_CMD    = 4'h8;
  localparam logic [3:0] OFS_STATUS = 4'hC;

  localparam int CMD_EN_BIT  = 0;
  localparam int CMD_IRQ_BIT = 1;
  localparam int CMD_SRC_LSB = 2;

  localparam int ST_BUSY_BIT = 0;
  localparam int ST_DONE_BIT = 1;
  localparam int ST_ERR_BIT  = 2;

  // Word addresses advance by four bytes.
  function automatic logic [31:0] addr_step(input logic [31:0] a);
    return a + 32'd4;
  endfunction

  function automatic logic [31:0] pack_status(input logic busy, input logic done,
                                              input logic err);
    logic [31:0] s;
    s = '0;
    s[ST_BUSY_BIT] = busy;
    s[ST_DONE_BIT] = done;
    s[ST_ERR_BIT]  = err;
    return s;
  endfunction
endpackage

// File: rtl/dmaeng_src_mux.sv
module dmaeng_src_mux #(
  parameter int NUM_SRC = 2,
  parameter int DATA_W  = 32,
  parameter int SRC_W   = 1
) (
  input  logic [SRC_W-1:0]          sel,
  input  logic [NUM_SRC-1:0]        valid_i,
  input  logic [NUM_SRC*DATA_W-1:0] data_i,
  input  logic                      take_i,
  output logic [NUM_SRC-1:0]        ready_o,
  output logic                      valid_o,
  output logic [DATA_W-1:0]         data_o
);
  logic sel_ok;
  assign sel_ok = (int'(sel) < NUM_SRC);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ready
    assign ready_o[g] = take_i && (int'(sel) == g);
  end

  always_comb begin
    valid_o = 1'b0;
    data_o  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_ok && int'(sel) == i) begin
        valid_o = valid_i[i];
        data_o  = data_i[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/dmaeng_regs.sv
module dmaeng_regs
  import dmaeng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int SRC_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              busy_i,
  input  logic              done_evt_i,
  input  logic              err_evt_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [SRC_W-1:0]  src_o,
  output logic              irq_o,
  output logic              start_o,
  output logic              zero_o,
  output logic              done_o,
  output logic              err_o
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  count_q;
  logic              en_q, irq_en_q;
  logic [SRC_W-1:0]  src_q;
  logic              done_q, err_q;
  logic              wr_base, wr_count, wr_cmd, wr_status, start_req;
  logic              unused_wdata;

  assign unused_wdata = &{1'b0, cfg_wdata};

  assign wr_base   = cfg_wr && cfg_addr == OFS_BASE   && !busy_i;
  assign wr_count  = cfg_wr && cfg_addr == OFS_COUNT  && !busy_i;
  assign wr_cmd    = cfg_wr && cfg_addr == OFS_CMD    && !busy_i;
  assign wr_status = cfg_wr && cfg_addr == OFS_STATUS;
  assign start_req = wr_cmd && cfg_wdata[CMD_EN_BIT];
  assign start_o   = start_req && (count_q != '0);
  assign zero_o    = start_req && (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      count_q  <= '0;
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      src_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (wr_base)  base_q  <= cfg_wdata[ADDR_W-1:0];
      if (wr_count) count_q <= cfg_wdata[CNT_W-1:0];
      if (wr_cmd) begin
        en_q     <= cfg_wdata[CMD_EN_BIT];
        irq_en_q <= cfg_wdata[CMD_IRQ_BIT];
        src_q    <= cfg_wdata[CMD_SRC_LSB +: SRC_W];
      end
      // Clear first, events last so that a same-cycle event wins.
      if (start_req) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (wr_status && cfg_wdata[ST_DONE_BIT]) done_q <= 1'b0;
      if (wr_status && cfg_wdata[ST_ERR_BIT])  err_q  <= 1'b0;
      if (done_evt_i || zero_o) done_q <= 1'b1;
      if (err_evt_i)            err_q  <= 1'b1;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      OFS_BASE:   cfg_rdata = 32'(base_q);
      OFS_COUNT:  cfg_rdata = 32'(count_q);
      OFS_CMD: begin
        cfg_rdata[CMD_EN_BIT]              = en_q;
        cfg_rdata[CMD_IRQ_BIT]             = irq_en_q;
        cfg_rdata[CMD_SRC_LSB +: SRC_W]    = src_q;
      end
      OFS_STATUS: cfg_rdata = pack_status(busy_i, done_q, err_q);
      default:    cfg_rdata = '0;
    endcase
  end

  assign base_o  = base_q;
  assign count_o = count_q;
  assign src_o   = src_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign irq_o   = (done_q || err_q) && irq_en_q;
endmodule

// File: rtl/dmaeng_mover.sv
module dmaeng_mover
  import dmaeng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              gnt_i,
  input  logic              err_i,
  output logic              busy_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              take_o,
  output logic              last_o,
  output logic              done_evt_o,
  output logic              err_evt_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] cur_q;
  logic [CNT_W-1:0]  rem_q;
  logic              fire;
  logic [31:0]       next_full;

  assign next_full  = addr_step(32'(cur_q));
  assign req_o      = busy_q && word_valid_i;
  assign take_o     = busy_q && gnt_i;
  assign fire       = req_o && gnt_i;
  assign last_o     = (rem_q == CNT_W'(1));
  assign done_evt_o = fire && !err_i && last_o;
  assign err_evt_o  = fire && err_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      rem_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cur_q  <= base_i;
      rem_q  <= count_i;
    end else if (fire) begin
      if (err_i || last_o) begin
        busy_q <= 1'b0;
      end else begin
        cur_q <= next_full[ADDR_W-1:0];
        rem_q <= rem_q - CNT_W'(1);
      end
    end
  end

  assign busy_o  = busy_q;
  assign addr_o  = cur_q;
  assign wdata_o = word_i;
endmodule

// File: rtl/dma_wr_engine.sv
module dma_wr_engine #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr,
  input  logic [3:0]                cfg_addr,
  input  logic [31:0]               cfg_wdata,
  output logic [31:0]               cfg_rdata,
  input  logic [NUM_SRC-1:0]        dev_valid,
  input  logic [NUM_SRC*DATA_W-1:0] dev_data,
  output logic [NUM_SRC-1:0]        dev_ready,
  output logic                      mem_req,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic                      mem_gnt,
  input  logic                      mem_err,
  output logic                      irq
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  // Named internal events, also observed by the bound checker.
  logic              busy, start_evt, zero_evt, done_evt, err_evt, rem_last, take;
  logic              done_q, err_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  count_q;
  logic [SRC_W-1:0]  src_sel;
  logic              word_valid;
  logic [DATA_W-1:0] word;

  dmaeng_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy_i(busy),
    .done_evt_i(done_evt), .err_evt_i(err_evt), .base_o(base_q),
    .count_o(count_q), .src_o(src_sel), .irq_o(irq), .start_o(start_evt),
    .zero_o(zero_evt), .done_o(done_q), .err_o(err_q)
  );

  dmaeng_src_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .SRC_W(SRC_W)) u_mux (
    .sel(src_sel), .valid_i(dev_valid), .data_i(dev_data), .take_i(take),
    .ready_o(dev_ready), .valid_o(word_valid), .data_o(word)
  );

  dmaeng_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .start_i(start_evt), .base_i(base_q),
    .count_i(count_q), .word_valid_i(word_valid), .word_i(word),
    .gnt_i(mem_gnt), .err_i(mem_err), .busy_o(busy), .req_o(mem_req),
    .addr_o(mem_addr), .wdata_o(mem_wdata), .take_o(take), .last_o(rem_last),
    .done_evt_o(done_evt), .err_evt_o(err_evt)
  );
endmodule

// File: rtl/dmaeng_chk.sv
module dmaeng_chk #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic               busy,
  input logic               mem_req,
  input logic               mem_gnt,
  input logic               mem_err,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [NUM_SRC-1:0] dev_ready,
  input logic [ADDR_W-1:0]  base_q,
  input logic [CNT_W-1:0]   count_q,
  input logic               done_q,
  input logic               err_q,
  input logic               zero_evt,
  input logic               rem_last,
  input logic               irq
);
  assert_req_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && !mem_err && !rem_last) |=>
      mem_addr == $past(mem_addr) + ADDR_W'(4));

  assert_final_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && !mem_err && rem_last) |=> (!busy && done_q));

  assert_zero_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (done_q && !mem_req && !busy));

  assert_one_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ready));

  assert_err_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && mem_err) |=> (!busy && err_q && !done_q));

  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(cfg_wr));

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(base_q) && $stable(count_q)));
endmodule

bind dma_wr_engine dmaeng_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .busy(busy), .mem_req(mem_req),
  .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_addr(mem_addr),
  .dev_ready(dev_ready), .base_q(base_q), .count_q(count_q), .done_q(done_q),
  .err_q(err_q), .zero_evt(zero_evt), .rem_last(rem_last), .irq(irq)
);

// File: tb/tb_dma_wr_engine.sv
module tb_dma_wr_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = 4'h0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  dev_valid = '0;
  logic [63:0] dev_data = '0;
  logic [1:0]  dev_ready;
  logic        mem_req;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0;
  logic        mem_err = 1'b0;
  logic        irq;

  dma_wr_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_valid(dev_valid),
    .dev_data(dev_data), .dev_ready(dev_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_err(mem_err), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  int gnt_mode = 0;     // 0 always, 1 alternate cycles, 2 never
  int stall_src = 0;    // 1: stream valid two cycles in three
  int err_at = -1;      // beat index within a test that gets an error
  int beat_base = 0;
  int beat_no = 0, n_log = 0, req_seen = 0, ready0_seen = 0;
  int sent [2] = '{0, 0};
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];

  function automatic logic [31:0] pattern(input int s, input int k);
    return 32'hC0DE_0000 | (32'(s) << 12) | (32'(k) & 32'hFFF);
  endfunction

  // Monitor and stream bookkeeping at the active edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) req_seen <= req_seen + 1;
    if (dev_ready[0]) ready0_seen <= ready0_seen + 1;
    if (mem_req && mem_gnt) begin
      beat_no <= beat_no + 1;
      if (!mem_err && n_log < 64) begin
        log_addr[n_log] <= mem_addr;
        log_data[n_log] <= mem_wdata;
        n_log <= n_log + 1;
      end
    end
    for (int s = 0; s < 2; s++)
      if (dev_valid[s] && dev_ready[s]) sent[s] <= sent[s] + 1;
  end

  // Stimulus for streams and memory, driven away from the active edge.
  always @(negedge clk) begin
    for (int s = 0; s < 2; s++) begin
      dev_valid[s] <= rst_n && (stall_src == 0 || (cyc % 3) != 0);
      dev_data[s*32 +: 32] <= pattern(s, sent[s]);
    end
    mem_gnt <= (gnt_mode == 0) ? 1'b1 : (gnt_mode == 1) ? cyc[0] : 1'b0;
    mem_err <= (err_at >= 0) && ((beat_no - beat_base) == err_at);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 2000; i++) begin
      rd(4'hC, st);
      if (!st[0]) return;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v); check("R1 base reset", v, 32'h0);
    rd(4'h4, v); check("R1 count reset", v, 32'h0);
    rd(4'h8, v); check("R1 cmd reset", v, 32'h0);
    rd(4'hC, v); check("R1 status reset", v, 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs_noenable();
    logic [31:0] v;
    int r0;
    wr(4'h0, 32'h0000_2000);
    wr(4'h4, 32'd3);
    r0 = req_seen;
    wr(4'h8, 32'h6);   // source 1, irq enable, transfer enable clear
    rd(4'h0, v); check("R1 base readback", v, 32'h0000_2000);
    rd(4'h4, v); check("R1 count readback", v, 32'd3);
    rd(4'h8, v); check("R1 cmd readback", v, 32'h6);
    repeat (4) @(negedge clk);
    rd(4'hC, v); check("R10 no start status", v, 32'h0);
    check("R10 no request", 32'(req_seen - r0), 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    int l0, s0;
    gnt_mode = 0; stall_src = 0; err_at = -1;
    l0 = n_log; s0 = sent[0];
    wr(4'h0, 32'h0000_1000);
    wr(4'h4, 32'd5);
    wr(4'h8, 32'h3);   // enable, irq enable, source 0
    wait_idle();
    check("R4 write count", 32'(n_log - l0), 32'd5);
    for (int i = 0; i < 5; i++) begin
      check("R2 R3 address", log_addr[l0+i], 32'h1000 + 32'(4*i));
      check("R3 data", log_data[l0+i], pattern(0, s0 + i));
    end
    rd(4'hC, v); check("R4 status done", v, 32'h2);
    check("R8 irq on done", {31'b0, irq}, 32'h1);
    wr(4'hC, 32'h0); rd(4'hC, v); check("R8 write zero keeps done", v, 32'h2);
    wr(4'hC, 32'h2); rd(4'hC, v); check("R8 clear done", v, 32'h0);
    check("R8 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_stall_src1();
    logic [31:0] v;
    int l0, s1, rd0;
    gnt_mode = 1; stall_src = 1; err_at = -1;
    l0 = n_log; s1 = sent[1]; rd0 = ready0_seen;
    wr(4'h0, 32'h0004_0000);
    wr(4'h4, 32'd7);
    wr(4'h8, 32'h5);   // enable, source 1, irq disabled
    wait_idle();
    check("R4 stalled write count", 32'(n_log - l0), 32'd7);
    for (int i = 0; i < 7; i++) begin
      check("R3 stalled address", log_addr[l0+i], 32'h0004_0000 + 32'(4*i));
      check("R6 source 1 data", log_data[l0+i], pattern(1, s1 + i));
    end
    check("R6 stream 0 never ready", 32'(ready0_seen - rd0), 32'h0);
    rd(4'hC, v); check("R4 done after stall", v, 32'h2);
    check("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(4'hC, 32'h2);
    stall_src = 0; gnt_mode = 0;
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int r0, l0;
    wr(4'h4, 32'd0);
    r0 = req_seen; l0 = n_log;
    wr(4'h8, 32'h3);
    rd(4'hC, v); check("R5 zero count done", v, 32'h2);
    check("R5 no request", 32'(req_seen - r0), 32'h0);
    check("R5 no write", 32'(n_log - l0), 32'h0);
    check("R8 irq on zero", {31'b0, irq}, 32'h1);
    wr(4'hC, 32'h2);
  endtask

  task automatic t_error();
    logic [31:0] v;
    int l0;
    gnt_mode = 0;
    l0 = n_log;
    @(negedge clk); beat_base = beat_no; err_at = 3;
    wr(4'h0, 32'h0000_8000);
    wr(4'h4, 32'd6);
    wr(4'h8, 32'h3);
    wait_idle();
    err_at = -1;
    check("R7 writes before error", 32'(n_log - l0), 32'd3);
    check("R7 last good address", log_addr[l0+2], 32'h0000_8008);
    rd(4'hC, v); check("R7 status error", v, 32'h4);
    check("R8 irq on error", {31'b0, irq}, 32'h1);
    wr(4'hC, 32'h4); rd(4'hC, v); check("R8 clear error", v, 32'h0);
    check("R8 irq after error clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int l0;
    gnt_mode = 2;
    l0 = n_log;
    wr(4'h0, 32'h0000_3000);
    wr(4'h4, 32'd4);
    wr(4'h8, 32'h1);
    wr(4'h0, 32'h0000_9990);
    wr(4'h4, 32'd9);
    wr(4'h8, 32'h6);
    rd(4'h0, v); check("R9 base held", v, 32'h0000_3000);
    rd(4'h4, v); check("R9 count held", v, 32'd4);
    rd(4'h8, v); check("R9 cmd held", v, 32'h1);
    rd(4'hC, v); check("R2 busy", v, 32'h1);
    gnt_mode = 0;
    wait_idle();
    check("R9 write count", 32'(n_log - l0), 32'd4);
    check("R9 first address", log_addr[l0], 32'h0000_3000);
    check("R9 last address", log_addr[l0+3], 32'h0000_300C);
    rd(4'hC, v); check("R9 done", v, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs_noenable();
    t_basic();
    t_stall_src1();
    t_zero();
    t_error();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule